// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Superpages

This block is a small, fully associative cache of address translations for use next to a processor's load/store path. Each of its entries maps one virtual page, or one aligned superpage that spans a group of pages, to a physical frame. Each entry carries the identifier of the process that owns it and a small access field. Because every entry carries a process tag, switching from one process to another only changes the `cur_pid` input. The stored translations of other processes stay in place and simply stop matching.

A lookup is combinational and completes in the same cycle. It returns a hit flag, the physical address, the access bits and a write-protection fault flag. The fault flag lets the kernel emulate a modified bit by trapping on the first store to a clean page. After a miss the requester walks its own tables and then loads the translation through the command port. The same command port can remove every translation that covers one (process, page) pair, which is used for shootdown after a permission change, or it can empty the whole cache. The table walk and the memory system are outside this block.

Top module: `tlb_tagged`

## Requirements
- R1: After reset no entry is valid, so every lookup reports `lk_hit`=0 and `lk_wfault`=0.
- R2: An entry covers a lookup only when it is valid, its stored process tag equals `cur_pid`, and its page tag matches. The same page under another process misses.
- R3: A small-page entry compares all VA_W-PAGE_OFF virtual page bits. On a hit, `lk_paddr` is {stored frame, `lk_vaddr`[PAGE_OFF-1:0]}.
- R4: A superpage entry (`cmd_super`=1) ignores the low SP_BITS bits of the page number, both at fill time and at lookup time. On a hit, `lk_paddr` is {frame[PFN_W-1:SP_BITS], `lk_vaddr`[PAGE_OFF+SP_BITS-1:0]}.
- R5: When several entries cover a lookup, a small-page entry wins over any superpage entry. Within the same size, the lowest entry index wins.
- R6: Bit 0 of the access field means writable. A lookup with `lk_write`=1 that is covered by an entry whose bit 0 is 0 gives `lk_wfault`=1 and `lk_hit`=0. Reads, and writes to writable entries, never fault. `lk_acc` shows the access field of the selected entry.
- R7: A fill (`cmd_op`=2'b01) that matches no existing entry writes the slot under a round-robin pointer. The pointer then advances modulo ENTRIES, so the (ENTRIES+1)-th new fill after reset evicts the first one.
- R8: A fill whose process tag, size and masked page tag equal those of a valid entry overwrites that entry in place. It creates no duplicate and leaves the pointer unchanged.
- R9: A page invalidate (`cmd_op`=2'b10) clears every entry that would cover a lookup of (`cmd_pid`, `cmd_vpn`). Entries of other processes and other pages are untouched.
- R10: A full flush (`cmd_op`=2'b11) clears every entry.
- R11: A command presented in one cycle changes lookup results from the cycle after the rising edge on which it is sampled. `cmd_op`=2'b00 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_pid | input | PID_W | Identifier of the running process |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | Lookup is a store |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_wfault | output | 1 | Store hit a non-writable entry; must trap |
| lk_paddr | output | PA_W | Translated physical address (0 on miss) |
| lk_acc | output | ACC_W | Access field of the selected entry (0 on miss) |
| cmd_op | input | 2 | 00 none, 01 fill, 10 page invalidate, 11 flush |
| cmd_pid | input | PID_W | Process tag for fill or page invalidate |
| cmd_vpn | input | VA_W-PAGE_OFF | Virtual page number for fill or page invalidate |
| cmd_pfn | input | PA_W-PAGE_OFF | Frame number for fill |
| cmd_super | input | 1 | Fill is a superpage |
| cmd_acc | input | ACC_W | Access field for fill |

## Verification
The assertions assume the command port carries at most one operation per cycle. They also assume that lookup inputs are stable around the clock edge, since the lookup outputs are sampled there. The stimulus changes commands only at the falling edge and returns `cmd_op` to 00 one cycle later. Lookups are driven only while no command is pending. The stimulus also never fills two entries of the same size and tag for one process except through the overwrite path, so the no-duplicate property holds. Sweeps cover four process tags and 128 page numbers, with both reads and writes, after each phase of fills, overwrites, nested superpage and small-page mappings, page invalidations and a flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    CMD_NOP      = 2'b00,
    CMD_FILL     = 2'b01,
    CMD_INV_PAGE = 2'b10,
    CMD_INV_ALL  = 2'b11
  } tlb_cmd_e;

  // position of the writable flag inside the access field
  localparam int ACC_WR_BIT = 0;
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
  parameter int VPN_W   = 20,
  parameter int PID_W   = 4,
  parameter int SP_BITS = 4
) (
  input  logic             ent_valid,
  input  logic             ent_sup,
  input  logic [PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [PID_W-1:0] q_pid,
  input  logic [VPN_W-1:0] q_vpn,
  output logic             covers
);
  localparam logic [VPN_W-1:0] SP_MASK = {{(VPN_W-SP_BITS){1'b1}}, {SP_BITS{1'b0}}};

  logic [VPN_W-1:0] cmp_mask;

  always_comb begin
    cmp_mask = ent_sup ? SP_MASK : '1;
    covers   = ent_valid && (ent_pid == q_pid) && (((ent_vpn ^ q_vpn) & cmp_mask) == '0);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     small_hit,
  input  logic [N-1:0]     super_hit,
  output logic             any_o,
  output logic             is_super_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o      = |(small_hit | super_hit);
    is_super_o = ~(|small_hit) & (|super_hit);
    idx_o      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (is_super_o ? super_hit[i] : small_hit[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R7: the pointer steps by one with wrap only on a fresh fill
  a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
  a_r7_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
  import tlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PAGE_OFF = 12,
  parameter int SP_BITS  = 4,
  parameter int PID_W    = 4,
  parameter int ENTRIES  = 8,
  parameter int ACC_W    = 2
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic [PID_W-1:0]         cur_pid,
  input  logic [VA_W-1:0]          lk_vaddr,
  input  logic                     lk_write,
  output logic                     lk_hit,
  output logic                     lk_wfault,
  output logic [PA_W-1:0]          lk_paddr,
  output logic [ACC_W-1:0]         lk_acc,
  input  logic [1:0]               cmd_op,
  input  logic [PID_W-1:0]         cmd_pid,
  input  logic [VA_W-PAGE_OFF-1:0] cmd_vpn,
  input  logic [PA_W-PAGE_OFF-1:0] cmd_pfn,
  input  logic                     cmd_super,
  input  logic [ACC_W-1:0]         cmd_acc
);
  localparam int VPN_W  = VA_W - PAGE_OFF;
  localparam int PFN_W  = PA_W - PAGE_OFF;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SOFF_W = PAGE_OFF + SP_BITS;
  localparam logic [VPN_W-1:0]   VPN_SP_MASK = {{(VPN_W-SP_BITS){1'b1}}, {SP_BITS{1'b0}}};
  localparam logic [PFN_W-1:0]   PFN_SP_MASK = {{(PFN_W-SP_BITS){1'b1}}, {SP_BITS{1'b0}}};
  localparam logic [ENTRIES-1:0] ONE_HOT0    = {{(ENTRIES-1){1'b0}}, 1'b1};

  logic rst_n;

  tlb_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  tlb_cmd_e op;
  assign op = tlb_cmd_e'(cmd_op);

  // entry state
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENTRIES-1:0] sup_q;
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ACC_W-1:0]   acc_q [ENTRIES];

  logic [ENTRIES-1:0] lk_cov;
  logic [ENTRIES-1:0] lk_small;
  logic [ENTRIES-1:0] lk_super;
  logic [ENTRIES-1:0] cmd_cov;
  logic [ENTRIES-1:0] fill_same;
  logic [ENTRIES-1:0] wr_en;
  logic [ENTRIES-1:0] clr_en;

  logic [VPN_W-1:0] lk_vpn;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;

  assign lk_vpn   = lk_vaddr[VA_W-1:PAGE_OFF];
  assign fill_vpn = cmd_super ? (cmd_vpn & VPN_SP_MASK) : cmd_vpn;
  assign fill_pfn = cmd_super ? (cmd_pfn & PFN_SP_MASK) : cmd_pfn;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_tag_match #(.VPN_W(VPN_W), .PID_W(PID_W), .SP_BITS(SP_BITS)) u_lk (
      .ent_valid (valid_q[g]),
      .ent_sup   (sup_q[g]),
      .ent_pid   (pid_q[g]),
      .ent_vpn   (vpn_q[g]),
      .q_pid     (cur_pid),
      .q_vpn     (lk_vpn),
      .covers    (lk_cov[g])
    );

    tlb_tag_match #(.VPN_W(VPN_W), .PID_W(PID_W), .SP_BITS(SP_BITS)) u_cmd (
      .ent_valid (valid_q[g]),
      .ent_sup   (sup_q[g]),
      .ent_pid   (pid_q[g]),
      .ent_vpn   (vpn_q[g]),
      .q_pid     (cmd_pid),
      .q_vpn     (cmd_vpn),
      .covers    (cmd_cov[g])
    );

    assign lk_small[g]  = lk_cov[g] & ~sup_q[g];
    assign lk_super[g]  = lk_cov[g] & sup_q[g];
    assign fill_same[g] = cmd_cov[g] & (sup_q[g] == cmd_super);

    // payload registers: clock enable only, no reset needed (gated by valid)
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        sup_q[g] <= cmd_super;
        pid_q[g] <= cmd_pid;
        vpn_q[g] <= fill_vpn;
        pfn_q[g] <= fill_pfn;
        acc_q[g] <= cmd_acc;
      end
    end
  end

  // replacement
  logic             fill_found;
  logic [IDX_W-1:0] fill_idx;
  logic [IDX_W-1:0] rr_ptr;
  logic             rr_adv;

  always_comb begin
    fill_found = |fill_same;
    fill_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_same[i]) fill_idx = IDX_W'(i);
    end
  end

  tlb_rr_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (rr_adv),
    .ptr   (rr_ptr)
  );

  // next state
  always_comb begin
    wr_en  = '0;
    clr_en = '0;
    rr_adv = 1'b0;
    case (op)
      CMD_FILL: begin
        if (fill_found) begin
          wr_en = ONE_HOT0 << fill_idx;
        end else begin
          wr_en  = ONE_HOT0 << rr_ptr;
          rr_adv = 1'b1;
        end
      end
      CMD_INV_PAGE: clr_en = cmd_cov;
      CMD_INV_ALL:  clr_en = '1;
      default: ;
    endcase
    valid_d = (valid_q & ~clr_en) | wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // lookup
  logic             sel_any;
  logic             sel_super;
  logic [IDX_W-1:0] sel_idx;
  logic [PFN_W-1:0] sel_pfn;
  logic [ACC_W-1:0] sel_acc;
  logic             wr_denied;

  tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .small_hit  (lk_small),
    .super_hit  (lk_super),
    .any_o      (sel_any),
    .is_super_o (sel_super),
    .idx_o      (sel_idx)
  );

  always_comb begin
    sel_pfn   = pfn_q[sel_idx];
    sel_acc   = acc_q[sel_idx];
    wr_denied = sel_any & lk_write & ~sel_acc[ACC_WR_BIT];
    lk_wfault = wr_denied;
    lk_hit    = sel_any & ~wr_denied;
    lk_acc    = sel_any ? sel_acc : '0;
    if (!sel_any)       lk_paddr = '0;
    else if (sel_super) lk_paddr = {sel_pfn[PFN_W-1:SP_BITS], lk_vaddr[SOFF_W-1:0]};
    else                lk_paddr = {sel_pfn, lk_vaddr[PAGE_OFF-1:0]};
  end

  // R5: selection honours small-page priority and points at a covering entry
  a_r5_small_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|lk_small) |-> (!sel_super && lk_small[sel_idx]));
  // R6: a fault only comes from a non-writable selected entry on a store
  a_r6_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lk_wfault |-> (lk_write && !lk_acc[ACC_WR_BIT] && !lk_hit));
  // R8: a fill never sees more than one entry with its own tag
  a_r8_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CMD_FILL) |-> ($countones(fill_same) <= 1));
  // R9: covered entries are gone after a page invalidate
  a_r9_page_gone: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CMD_INV_PAGE) |=> ((valid_q & $past(cmd_cov)) == '0));
  // R10: flush leaves nothing valid
  a_r10_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CMD_INV_ALL) |=> (valid_q == '0));
endmodule

// File: tb/tb_tlb_tagged.sv
module tb_tlb_tagged;
  localparam int CLK_NS = 8;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [3:0]  cur_pid;
  logic [31:0] lk_vaddr;
  logic        lk_write;
  logic        lk_hit, lk_wfault;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_acc;
  logic [1:0]  cmd_op;
  logic [3:0]  cmd_pid;
  logic [19:0] cmd_vpn;
  logic [19:0] cmd_pfn;
  logic        cmd_super;
  logic [1:0]  cmd_acc;

  always #(CLK_NS/2) clk = ~clk;

  tlb_tagged dut (
    .clk(clk), .arst_n(arst_n), .cur_pid(cur_pid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_hit(lk_hit), .lk_wfault(lk_wfault),
    .lk_paddr(lk_paddr), .lk_acc(lk_acc), .cmd_op(cmd_op), .cmd_pid(cmd_pid),
    .cmd_vpn(cmd_vpn), .cmd_pfn(cmd_pfn), .cmd_super(cmd_super), .cmd_acc(cmd_acc)
  );

  int n_chk = 0;
  int n_err = 0;

  // reference model built from the requirements
  bit m_v [N];
  bit m_sup [N];
  int m_pid [N];
  int m_vpn [N];
  int m_pfn [N];
  int m_acc [N];
  int m_ptr = 0;

  function automatic bit m_covers(int i, int pid, int vpn);
    if (!m_v[i] || m_pid[i] != pid) return 0;
    if (m_sup[i]) return (m_vpn[i] >> 4) == (vpn >> 4);
    return m_vpn[i] == vpn;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, int pid, int vpn, int pfn, bit sup, int acc);
    @(negedge clk);
    cmd_op = op; cmd_pid = 4'(pid); cmd_vpn = 20'(vpn);
    cmd_pfn = 20'(pfn); cmd_super = sup; cmd_acc = 2'(acc);
    @(negedge clk);
    cmd_op = 2'b00;
  endtask

  task automatic do_fill(int pid, int vpn, int pfn, bit sup, int acc);
    int slot = -1;
    for (int i = 0; i < N; i++)
      if (slot < 0 && m_covers(i, pid, vpn) && m_sup[i] == sup) slot = i;
    if (slot < 0) begin
      slot = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_v[slot] = 1; m_sup[slot] = sup; m_pid[slot] = pid;
    m_vpn[slot] = sup ? (vpn & ~15) : vpn;
    m_pfn[slot] = sup ? (pfn & ~15) : pfn;
    m_acc[slot] = acc;
    issue(2'b01, pid, vpn, pfn, sup, acc);
  endtask

  task automatic do_inv(int pid, int vpn);
    for (int i = 0; i < N; i++) if (m_covers(i, pid, vpn)) m_v[i] = 0;
    issue(2'b10, pid, vpn, 0, 0, 0);
  endtask

  task automatic do_flush();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    issue(2'b11, 0, 0, 0, 0, 0);
  endtask

  task automatic look(string req, int pid, logic [31:0] va, bit wr);
    int sel = -1;
    int vpn = int'(va >> 12);
    bit match, e_wf, e_hit;
    logic [31:0] e_pa;
    for (int i = 0; i < N; i++)
      if (sel < 0 && m_covers(i, pid, vpn) && !m_sup[i]) sel = i;
    for (int i = 0; i < N; i++)
      if (sel < 0 && m_covers(i, pid, vpn) && m_sup[i]) sel = i;
    match = (sel >= 0);
    cur_pid = 4'(pid); lk_vaddr = va; lk_write = wr;
    #1;
    e_wf  = match && wr && ((m_acc[sel < 0 ? 0 : sel] & 1) == 0);
    e_hit = match && !e_wf;
    chk(req, "hit", 32'(lk_hit), 32'(e_hit));
    chk(req, "wfault", 32'(lk_wfault), 32'(e_wf));
    if (match) begin
      if (m_sup[sel]) e_pa = ((32'(m_pfn[sel]) >> 4) << 16) | (va & 32'hFFFF);
      else            e_pa = (32'(m_pfn[sel]) << 12) | (va & 32'hFFF);
      chk(req, "paddr", lk_paddr, e_pa);
      chk(req, "acc", 32'(lk_acc), 32'(m_acc[sel]));
    end
  endtask

  task automatic sweep(string req);
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 128; v++)
        look(req, p, (32'(v) << 12) | 32'((v * 37 + p * 101) & 12'hFFF), bit'((v + p) & 1));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    arst_n = 1'b0; cur_pid = '0; lk_vaddr = '0; lk_write = 1'b0;
    cmd_op = 2'b00; cmd_pid = '0; cmd_vpn = '0; cmd_pfn = '0; cmd_super = 1'b0; cmd_acc = '0;
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: empty after reset
    sweep("R1");

    // R3/R6: eight small pages, even slots writable
    for (int i = 0; i < N; i++)
      do_fill(1, 5 + 3 * i, 16'h100 + 7 * i, 0, (i % 2) ? 2 : 1);
    for (int i = 0; i < N; i++) begin
      look("R3", 1, (32'(5 + 3 * i) << 12) | 32'h0ABC, 0);
      look("R6", 1, (32'(5 + 3 * i) << 12) | 32'h0123, 1);
      look("R2", 2, (32'(5 + 3 * i) << 12) | 32'h0123, 0);
    end
    sweep("R3");

    // R7/R2: ninth fill evicts slot 0; same page under another process
    do_fill(2, 5, 16'h900, 0, 3);
    look("R7", 1, 32'h0000_5010, 0);
    look("R2", 2, 32'h0000_5010, 1);

    // R8: overwrite in place, then two fresh fills
    do_fill(1, 11, 16'h555, 0, 1);
    look("R8", 1, 32'h0000_B777, 1);
    do_fill(3, 50, 16'h222, 0, 1);
    look("R8", 1, 32'h0000_B777, 0);
    do_fill(3, 51, 16'h223, 0, 1);
    look("R8", 1, 32'h0000_B777, 0);
    look("R8", 1, 32'h0000_E000, 0);
    sweep("R8");

    // R4/R5: superpage with a nested read-only small page
    do_fill(1, 16'h4A, 16'h8B, 1, 1);
    do_fill(1, 16'h43, 16'h333, 0, 0);
    look("R4", 1, 32'h0004_A123, 1);
    look("R5", 1, 32'h0004_3456, 1);
    look("R5", 1, 32'h0004_3456, 0);
    sweep("R4");
    do_fill(1, 16'h45, 16'hC7, 1, 3);
    look("R8", 1, 32'h0004_F001, 1);
    sweep("R5");

    // R9: wrong process leaves state, right one removes the superpage
    do_inv(2, 16'h44);
    look("R9", 1, 32'h0004_4000, 0);
    do_inv(1, 16'h47);
    look("R9", 1, 32'h0004_4000, 0);
    look("R9", 1, 32'h0004_3000, 0);
    sweep("R9");

    // R11: command with op 00 changes nothing
    issue(2'b00, 1, 16'h43, 0, 0, 0);
    look("R11", 1, 32'h0004_3000, 0);

    // R10: flush
    do_flush();
    sweep("R10");

    summary();
    $finish;
  end
endmodule